// File: doc/BRIEF.md
# Coprocessor Power Sequencer

This block brings a small always-on coprocessor up and down. It drives three signals to the coprocessor: a reset, a clock enable and a one-cycle start interrupt. A start strobe, or an armed pin event, turns on the clock at once. The reset is then released after a programmable number of cycles. A start interrupt follows after a second, independent delay.

When the coprocessor reports that it is done, the sequencer halts it. The halt gates its clock and puts it back into reset. A sleep timer then counts slow-clock ticks and restarts the coprocessor when the programmed period runs out. A shutdown request keeps the clock running for a programmable number of cycles under reset, then gates it. A force-on input keeps the clock enabled in every state.

Recommended configuration after power-up: reset delay 8, interrupt delay 16, gating delay 40 and sleep period 200.

Top module: `cop_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe applied, the sequencer is off. `cop_reset_o` is 1 (1 means the coprocessor is held in reset), `start_irq_o` is 0 and `cop_clk_en_o` equals `cfg_clk_force_i`.
- R2: A start is accepted in the cycle in which `start_i` is sampled high while the sequencer is off or halted. From the next cycle on, `cop_clk_en_o` is 1. `cop_reset_o` stays 1 for exactly `cfg_rst_dly_i` cycles and then goes to 0. A delay of 0 releases reset in the first starting cycle.
- R3: `start_irq_o` is a single-cycle pulse. It comes exactly `cfg_irq_dly_i` cycles after the first starting cycle, so a value of 0 pulses in that first cycle. The start phase ends, and the coprocessor is running, once both delays have elapsed.
- R4: A `done_i` sampled while running halts the coprocessor from the next cycle. `cop_reset_o` goes to 1 and `cop_clk_en_o` drops unless forced.
- R5: While halted with `cfg_timer_en_i` at 1, the sleep timer counts the cycles in which `slow_tick_i` is 1. After `cfg_sleep_cycles_i` counted ticks a new start sequence begins, as in R2. A period of 0 restarts after one halted cycle.
- R6: While `cfg_timer_en_i` is 0, the sleep timer neither counts nor expires, and the coprocessor stays halted. Counting resumes from the held value when the enable returns to 1.
- R7: A `shut_i` sampled while starting, running or halted starts the shutdown. The next cycle and the following `cfg_gate_dly_i` cycles keep `cop_clk_en_o` at 1 and `cop_reset_o` at 1. The clock is then gated and the sequencer is off.
- R8: `cfg_clk_force_i` at 1 holds `cop_clk_en_o` at 1 in every state, including off and halted.
- R9: A pin wake-up arm bit is set by `wake_arm_set_i` and cleared by `wake_arm_clr_i`, with clear winning when both are high. The new value applies from the next cycle. `pin_wake_i` acts as a start only when the arm bit is already 1 and the sequencer is off or halted.
- R10: `shut_i` takes priority over `done_i` and over start sources in the same cycle. `start_i` is ignored while starting, running or shutting down, and `done_i` is ignored outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst_dly_i | input | 6 | Cycles from start to reset release |
| cfg_irq_dly_i | input | 6 | Cycles from start to the start interrupt |
| cfg_gate_dly_i | input | 8 | Cycles from shutdown to clock gating |
| cfg_sleep_cycles_i | input | 24 | Slow ticks in the sleep period |
| cfg_timer_en_i | input | 1 | Sleep timer enable |
| cfg_clk_force_i | input | 1 | Keep coprocessor clock enabled |
| start_i | input | 1 | Start strobe |
| done_i | input | 1 | Done strobe from the coprocessor |
| shut_i | input | 1 | Shutdown request strobe |
| wake_arm_set_i | input | 1 | Set the pin wake-up arm bit |
| wake_arm_clr_i | input | 1 | Clear the pin wake-up arm bit |
| pin_wake_i | input | 1 | Pin wake-up event |
| slow_tick_i | input | 1 | One-cycle tick per slow-clock cycle |
| cop_reset_o | output | 1 | Coprocessor reset, 1 = held in reset |
| cop_clk_en_o | output | 1 | Coprocessor clock enable |
| start_irq_o | output | 1 | Start interrupt pulse |

## Verification
The hardest situation to reach is a halted coprocessor whose timer is partly counted and is then frozen. The bench has to enter the halted state, run a tick pattern for part of the period, drop the timer enable for far longer than the remaining period, and then check that the restart comes only after the leftover ticks. The stimulus does this with a sparse tick divider and a short period. Same-cycle collisions are also hard to reach, since the strobes must land in the exact cycle of a state: shutdown meeting done, arm set meeting arm clear, and a pin event one cycle after arming. These are driven with strobes placed relative to the known entry cycle of each state.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF      = 3'd0,
    SEQ_STARTING = 3'd1,
    SEQ_RUNNING  = 3'd2,
    SEQ_HALTED   = 3'd3,
    SEQ_SHUTTING = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cop_seq_wake_arm.sv
module cop_seq_wake_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);

  logic armed_q;
  logic armed_d;
  logic armed_we;

  // Write enable is explicit: the bit only moves on a set or clear strobe.
  always_comb begin
    armed_we = set_i | clr_i;
    armed_d  = set_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_we) begin
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  AST_WAKE_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !armed_o); // R9

  AST_WAKE_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> armed_o); // R9

endmodule

// File: rtl/cop_seq_phase_cnt.sv
module cop_seq_phase_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_we;

  always_comb begin
    cnt_we = clr_i | (cnt_q != CNT_MAX);
    cnt_d  = clr_i ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_PHASE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> (cnt_q >= $past(cnt_q))); // R7

endmodule

// File: rtl/cop_seq_sleep_tmr.sv
module cop_seq_sleep_tmr #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_we;

  always_comb begin
    cnt_we = clr_i | (en_i & tick_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = en_i & (cnt_q >= limit_i);

  AST_TMR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R6

  AST_TMR_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
  import cop_seq_pkg::*;
#(
  parameter int unsigned RST_W  = 6,
  parameter int unsigned IRQ_W  = 6,
  parameter int unsigned GATE_W = 8,
  parameter int unsigned PH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RST_W-1:0]  rst_dly_i,
  input  logic [IRQ_W-1:0]  irq_dly_i,
  input  logic [GATE_W-1:0] gate_dly_i,
  input  logic              clk_force_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              shut_i,
  input  logic              wake_go_i,
  input  logic              tmr_expire_i,
  input  logic [PH_W-1:0]   ph_cnt_i,
  output logic              ph_clr_o,
  output logic              tmr_clr_o,
  output logic              cop_reset_o,
  output logic              cop_clk_en_o,
  output logic              start_irq_o
);

  seq_state_e state_q;
  seq_state_e state_d;

  logic [PH_W-1:0] rst_ext;
  logic [PH_W-1:0] irq_ext;
  logic [PH_W-1:0] gate_ext;
  logic            rst_met;
  logic            irq_met;
  logic            gate_met;
  logic            any_start;

  always_comb begin
    rst_ext   = PH_W'(rst_dly_i);
    irq_ext   = PH_W'(irq_dly_i);
    gate_ext  = PH_W'(gate_dly_i);
    rst_met   = (ph_cnt_i >= rst_ext);
    irq_met   = (ph_cnt_i >= irq_ext);
    gate_met  = (ph_cnt_i >= gate_ext);
    any_start = start_i | wake_go_i;
  end

  // Next-state process
  always_comb begin
    state_d   = state_q;
    ph_clr_o  = 1'b0;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      SEQ_OFF: begin
        if (any_start) begin
          state_d  = SEQ_STARTING;
          ph_clr_o = 1'b1;
        end
      end
      SEQ_STARTING: begin
        if (shut_i) begin
          state_d  = SEQ_SHUTTING;
          ph_clr_o = 1'b1;
        end else if (rst_met && irq_met) begin
          state_d = SEQ_RUNNING;
        end
      end
      SEQ_RUNNING: begin
        if (shut_i) begin
          state_d  = SEQ_SHUTTING;
          ph_clr_o = 1'b1;
        end else if (done_i) begin
          state_d   = SEQ_HALTED;
          tmr_clr_o = 1'b1;
        end
      end
      SEQ_HALTED: begin
        if (shut_i) begin
          state_d  = SEQ_SHUTTING;
          ph_clr_o = 1'b1;
        end else if (any_start || tmr_expire_i) begin
          state_d  = SEQ_STARTING;
          ph_clr_o = 1'b1;
        end
      end
      SEQ_SHUTTING: begin
        if (gate_met) begin
          state_d = SEQ_OFF;
        end
      end
      default: begin
        state_d = SEQ_OFF;
      end
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  // Output decode
  always_comb begin
    cop_reset_o  = ~((state_q == SEQ_RUNNING) ||
                     ((state_q == SEQ_STARTING) && rst_met));
    start_irq_o  = (state_q == SEQ_STARTING) && (ph_cnt_i == irq_ext);
    cop_clk_en_o = clk_force_i || (state_q == SEQ_STARTING) ||
                   (state_q == SEQ_RUNNING) || (state_q == SEQ_SHUTTING);
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq_o |=> !start_irq_o); // R3

  AST_RUN_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUNNING) |=> (state_q != SEQ_OFF)); // R7

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_HALTED) && ($past(state_q) != SEQ_HALTED)) |-> $past(done_i)); // R4

  AST_SHUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_RUNNING) && shut_i) |=> (state_q == SEQ_SHUTTING)); // R10

  AST_SHUT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SHUTTING) |-> (cop_reset_o && cop_clk_en_o)); // R7

endmodule

// File: rtl/cop_pwr_seq.sv
module cop_pwr_seq #(
  parameter int unsigned RST_DLY_W  = 6,
  parameter int unsigned IRQ_DLY_W  = 6,
  parameter int unsigned GATE_DLY_W = 8,
  parameter int unsigned SLEEP_W    = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RST_DLY_W-1:0]  cfg_rst_dly_i,
  input  logic [IRQ_DLY_W-1:0]  cfg_irq_dly_i,
  input  logic [GATE_DLY_W-1:0] cfg_gate_dly_i,
  input  logic [SLEEP_W-1:0]    cfg_sleep_cycles_i,
  input  logic                  cfg_timer_en_i,
  input  logic                  cfg_clk_force_i,
  input  logic                  start_i,
  input  logic                  done_i,
  input  logic                  shut_i,
  input  logic                  wake_arm_set_i,
  input  logic                  wake_arm_clr_i,
  input  logic                  pin_wake_i,
  input  logic                  slow_tick_i,
  output logic                  cop_reset_o,
  output logic                  cop_clk_en_o,
  output logic                  start_irq_o
);

  localparam int unsigned PH_W = cop_seq_pkg::max3(RST_DLY_W, IRQ_DLY_W, GATE_DLY_W);

  logic            armed;
  logic            wake_go;
  logic            ph_clr;
  logic            tmr_clr;
  logic            tmr_expire;
  logic [PH_W-1:0] ph_cnt;

  assign wake_go = armed & pin_wake_i;

  cop_seq_wake_arm u_wake_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wake_arm_set_i),
    .clr_i   (wake_arm_clr_i),
    .armed_o (armed)
  );

  cop_seq_phase_cnt #(.W(PH_W)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ph_clr),
    .cnt_o (ph_cnt)
  );

  cop_seq_sleep_tmr #(.W(SLEEP_W)) u_sleep_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .en_i     (cfg_timer_en_i),
    .tick_i   (slow_tick_i),
    .limit_i  (cfg_sleep_cycles_i),
    .expire_o (tmr_expire)
  );

  cop_seq_fsm #(
    .RST_W  (RST_DLY_W),
    .IRQ_W  (IRQ_DLY_W),
    .GATE_W (GATE_DLY_W),
    .PH_W   (PH_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_dly_i    (cfg_rst_dly_i),
    .irq_dly_i    (cfg_irq_dly_i),
    .gate_dly_i   (cfg_gate_dly_i),
    .clk_force_i  (cfg_clk_force_i),
    .start_i      (start_i),
    .done_i       (done_i),
    .shut_i       (shut_i),
    .wake_go_i    (wake_go),
    .tmr_expire_i (tmr_expire),
    .ph_cnt_i     (ph_cnt),
    .ph_clr_o     (ph_clr),
    .tmr_clr_o    (tmr_clr),
    .cop_reset_o  (cop_reset_o),
    .cop_clk_en_o (cop_clk_en_o),
    .start_irq_o  (start_irq_o)
  );

  AST_FORCE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_force_i |-> cop_clk_en_o); // R8

  AST_IRQ_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq_o |-> cop_clk_en_o); // R3

endmodule

// File: tb/cop_pwr_seq_tb.sv
module cop_pwr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_rst_dly;
  logic [5:0]  cfg_irq_dly;
  logic [7:0]  cfg_gate_dly;
  logic [23:0] cfg_sleep;
  logic        cfg_timer_en;
  logic        cfg_force;
  logic        start_s, done_s, shut_s, arm_set, arm_clr, pin_s, tick_s;
  logic        cop_reset, cop_clk_en, start_irq;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  int    tick_div = 1;
  int    tick_phase = 0;
  string cur_req = "R1";

  // behavioural reference: 0 off, 1 starting, 2 running, 3 halted, 4 shutting
  int m_state = 0;
  int m_cnt = 0;
  int m_tick = 0;
  bit m_arm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_pwr_seq u_dut (
    .clk                (clk),
    .rst_n              (rst_n),
    .cfg_rst_dly_i      (cfg_rst_dly),
    .cfg_irq_dly_i      (cfg_irq_dly),
    .cfg_gate_dly_i     (cfg_gate_dly),
    .cfg_sleep_cycles_i (cfg_sleep),
    .cfg_timer_en_i     (cfg_timer_en),
    .cfg_clk_force_i    (cfg_force),
    .start_i            (start_s),
    .done_i             (done_s),
    .shut_i             (shut_s),
    .wake_arm_set_i     (arm_set),
    .wake_arm_clr_i     (arm_clr),
    .pin_wake_i         (pin_s),
    .slow_tick_i        (tick_s),
    .cop_reset_o        (cop_reset),
    .cop_clk_en_o       (cop_clk_en),
    .start_irq_o        (start_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_tick = 0; m_arm = 0;
    end else begin
      bit go;
      go = start_s || (pin_s && m_arm);
      case (m_state)
        0: if (go) begin m_state = 1; m_cnt = 0; end
        1: begin
          if (shut_s) begin m_state = 4; m_cnt = 0; end
          else if (m_cnt >= int'(cfg_rst_dly) && m_cnt >= int'(cfg_irq_dly)) m_state = 2;
          else m_cnt++;
        end
        2: begin
          if (shut_s) begin m_state = 4; m_cnt = 0; end
          else if (done_s) begin m_state = 3; m_tick = 0; end
        end
        3: begin
          if (shut_s) begin m_state = 4; m_cnt = 0; end
          else if (go || (cfg_timer_en && m_tick >= int'(cfg_sleep))) begin
            m_state = 1; m_cnt = 0;
          end else if (cfg_timer_en && tick_s) m_tick++;
        end
        default: begin
          if (m_cnt >= int'(cfg_gate_dly)) m_state = 0;
          else m_cnt++;
        end
      endcase
      if (arm_clr) m_arm = 0;
      else if (arm_set) m_arm = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog %s: actual=%0d cycles expected<=%0d", cur_req, cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check_outputs();
    bit e_rst, e_irq, e_clk;
    e_rst = !(m_state == 2 || (m_state == 1 && m_cnt >= int'(cfg_rst_dly)));
    e_irq = (m_state == 1) && (m_cnt == int'(cfg_irq_dly));
    e_clk = cfg_force || m_state == 1 || m_state == 2 || m_state == 4;
    vectors++;
    if (cop_reset !== e_rst) begin
      miscompares++;
      $display("FAIL %s cop_reset_o t=%0t actual=%b expected=%b", cur_req, $time, cop_reset, e_rst);
    end
    if (start_irq !== e_irq) begin
      miscompares++;
      $display("FAIL %s start_irq_o t=%0t actual=%b expected=%b", cur_req, $time, start_irq, e_irq);
    end
    if (cop_clk_en !== e_clk) begin
      miscompares++;
      $display("FAIL %s cop_clk_en_o t=%0t actual=%b expected=%b", cur_req, $time, cop_clk_en, e_clk);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      tick_s = (tick_div > 0) && ((tick_phase % tick_div) == 0);
      tick_phase++;
    end
  endtask

  task automatic pulse_start();  start_s = 1; run(1); start_s = 0; endtask
  task automatic pulse_done();   done_s  = 1; run(1); done_s  = 0; endtask
  task automatic pulse_shut();   shut_s  = 1; run(1); shut_s  = 0; endtask
  task automatic pulse_pin();    pin_s   = 1; run(1); pin_s   = 0; endtask

  initial begin
    rst_n = 0;
    cfg_rst_dly = 6'd8; cfg_irq_dly = 6'd16; cfg_gate_dly = 8'd40;
    cfg_sleep = 24'd200; cfg_timer_en = 1; cfg_force = 0;
    start_s = 0; done_s = 0; shut_s = 0; arm_set = 0; arm_clr = 0; pin_s = 0; tick_s = 0;

    cur_req = "R1";
    run(3);
    rst_n = 1;
    run(4);

    cur_req = "R2";
    pulse_start();
    cur_req = "R3";
    run(25);

    cur_req = "R10";
    pulse_start();
    run(2);

    cur_req = "R4";
    pulse_done();
    run(3);
    cur_req = "R5";
    run(220);

    cur_req = "R6";
    pulse_done();
    cfg_sleep = 24'd5; tick_div = 3;
    run(7);
    cfg_timer_en = 0;
    run(300);
    cfg_timer_en = 1;
    run(40);

    cur_req = "R10";
    done_s = 1; shut_s = 1; run(1); done_s = 0; shut_s = 0;
    run(45);
    pulse_done();
    run(3);

    cur_req = "R8";
    cfg_force = 1;
    run(5);
    pulse_start();
    run(20);
    pulse_done();
    run(3);
    cfg_force = 0;
    run(3);

    cur_req = "R7";
    cfg_gate_dly = 8'd0;
    pulse_shut();
    run(4);
    cfg_gate_dly = 8'd40;

    cur_req = "R9";
    pulse_pin();
    run(2);
    arm_set = 1; arm_clr = 1; run(1); arm_set = 0; arm_clr = 0;
    pulse_pin();
    run(2);
    arm_set = 1; run(1); arm_set = 0;
    pulse_pin();
    run(25);
    arm_clr = 1; run(1); arm_clr = 0;
    cfg_timer_en = 0;
    pulse_done();
    pulse_pin();
    run(5);

    cur_req = "R2";
    cfg_timer_en = 1; cfg_sleep = 24'd0; tick_div = 1;
    cfg_rst_dly = 6'd0; cfg_irq_dly = 6'd0;
    run(4);
    cfg_timer_en = 0;
    pulse_done();
    run(2);
    cur_req = "R3";
    cfg_rst_dly = 6'd20; cfg_irq_dly = 6'd3;
    pulse_start();
    run(25);

    cur_req = "R7";
    cfg_gate_dly = 8'd40;
    pulse_shut();
    run(50);
    pulse_start();
    run(5);
    pulse_shut();
    run(45);
    pulse_done();
    pulse_start();
    run(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule